// File: doc/BRIEF.md
# RS485 Address-Match Receive Gate

This block sits between a 9-bit UART receiver and the receive FIFO of a node that acts as an addressable slave on a multi-drop RS485 bus. Every received character carries 8 data bits and a ninth bit. The ninth bit tells an address character apart from a data character. When automatic address detection is switched on, the block compares each address character against a programmable node address. It uses the result to open or close the path into the FIFO.

A matching address opens the gate. That address byte is itself forwarded into the FIFO, and a receiver-enable flag that software can read is raised. While the gate is open, every character is forwarded. A later address that does not match closes the gate, lowers the flag, and is not forwarded. Software can lower the flag at any time to stop reception early. When automatic detection is off, the gate forwards every character and the hardware never changes the flag.

Top module: `rs485_addr_gate`

## Requirements
- R1: During and straight after reset, `rx_enable` is 0 and `fifo_push` is 0.
- R2: A character with `rx_addr_flag` = 1 is an address character. Its 8 bits are compared with `node_addr`. A character with `rx_addr_flag` = 0 is a data character, and it never changes `rx_enable` even when its value equals `node_addr`.
- R3: With `auto_mode` = 1, a matching address character sets `rx_enable` and pushes that byte. Both the flag and the push appear in the cycle after the `rx_valid` strobe.
- R4: With `auto_mode` = 1, a non-matching address character clears `rx_enable` in the next cycle and is not pushed.
- R5: With `auto_mode` = 1 and `rx_enable` = 1, each data character is pushed one cycle after its strobe, with `fifo_data` equal to the received byte.
- R6: With `auto_mode` = 1 and `rx_enable` = 0, data characters cause no push.
- R7: `sw_clear` = 1 clears `rx_enable` in the next cycle. A data character strobed in the same cycle as the clear is still judged by the flag value from before the clear.
- R8: A matching address character and `sw_clear` in the same cycle leave `rx_enable` = 1 in the next cycle.
- R9: With `auto_mode` = 0, every strobed character (address or data) is pushed one cycle later. In this mode `rx_enable` changes only through `sw_clear`.
- R10: No cycle without an `rx_valid` strobe produces a push in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a character was received |
| rx_data | input | 8 | Received 8 data bits |
| rx_addr_flag | input | 1 | Ninth bit; 1 marks an address character |
| auto_mode | input | 1 | Enables automatic address detection |
| node_addr | input | 8 | Programmable node address |
| sw_clear | input | 1 | Software clear of the receiver-enable flag |
| fifo_push | output | 1 | Write strobe into the receive FIFO |
| fifo_data | output | 8 | Byte written into the FIFO |
| rx_enable | output | 1 | Receiver-enable flag |

## Verification
Two flag updates can land in the same cycle: the hardware set from a matching address and the software clear. The bench raises `sw_clear` during the strobe of a matching address and expects the flag to stay 1. It also raises `sw_clear` during a data character while the gate is open, and expects that character to be pushed while the flag drops. A reference model built from queues and integers predicts the push, the pushed byte and the flag on every clock, and the bench compares them against the design.

// File: rtl/rag_pkg.sv
package rag_pkg;

    typedef enum logic [1:0] {
        FK_NONE     = 2'd0,
        FK_DATA     = 2'd1,
        FK_ADDR_HIT = 2'd2,
        FK_ADDR_MISS= 2'd3
    } frame_kind_e;

endpackage

// File: rtl/rag_frame_class.sv
module rag_frame_class
    import rag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              addr_flag_i,
    input  logic [DATA_W-1:0] match_i,
    output frame_kind_e       kind_o
);

    always_comb begin
        if (!valid_i) begin
            kind_o = FK_NONE;
        end else if (!addr_flag_i) begin
            kind_o = FK_DATA;
        end else if (data_i == match_i) begin
            kind_o = FK_ADDR_HIT;
        end else begin
            kind_o = FK_ADDR_MISS;
        end
    end

endmodule

// File: rtl/rag_gate_decide.sv
module rag_gate_decide
    import rag_pkg::*;
(
    input  frame_kind_e kind_i,
    input  logic        auto_i,
    input  logic        flag_i,
    input  logic        clear_i,
    output logic        take_o,
    output logic        flag_o
);

    always_comb begin
        take_o = 1'b0;
        flag_o = flag_i & ~clear_i;
        if (auto_i) begin
            unique case (kind_i)
                FK_ADDR_HIT: begin
                    take_o = 1'b1;
                    flag_o = 1'b1;
                end
                FK_ADDR_MISS: begin
                    take_o = 1'b0;
                    flag_o = 1'b0;
                end
                FK_DATA: begin
                    take_o = flag_i;
                end
                default: begin
                    take_o = 1'b0;
                end
            endcase
        end else begin
            take_o = (kind_i != FK_NONE);
        end
    end

endmodule

// File: rtl/rs485_addr_gate.sv
module rs485_addr_gate
    import rag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_addr_flag,
    input  logic              auto_mode,
    input  logic [DATA_W-1:0] node_addr,
    input  logic              sw_clear,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    output logic              rx_enable
);

    localparam logic [DATA_W-1:0] DATA_ZERO = '0;

    typedef struct packed {
        logic              flag;
        logic              push;
        logic [DATA_W-1:0] data;
    } gate_state_t;

    gate_state_t st_d, st_q;
    frame_kind_e kind;
    logic        take;
    logic        flag_next;

    rag_frame_class #(.DATA_W(DATA_W)) i_class (
        .valid_i     (rx_valid),
        .data_i      (rx_data),
        .addr_flag_i (rx_addr_flag),
        .match_i     (node_addr),
        .kind_o      (kind)
    );

    rag_gate_decide i_decide (
        .kind_i  (kind),
        .auto_i  (auto_mode),
        .flag_i  (st_q.flag),
        .clear_i (sw_clear),
        .take_o  (take),
        .flag_o  (flag_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.flag = flag_next;
        st_d.push = take;
        st_d.data = take ? rx_data : st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b0, push: 1'b0, data: DATA_ZERO};
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_push = st_q.push;
    assign fifo_data = st_q.data;
    assign rx_enable = st_q.flag;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rx_enable && !fifo_push) || !rst_n);

    a_r3_hit_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && rx_valid && rx_addr_flag && rx_data == node_addr)
        |=> (rx_enable && fifo_push && fifo_data == $past(rx_data)));

    a_r4_miss_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && rx_valid && rx_addr_flag && rx_data != node_addr)
        |=> (!rx_enable && !fifo_push));

    a_r6_closed_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && rx_valid && !rx_addr_flag && !rx_enable) |=> !fifo_push);

    a_r7_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !(auto_mode && rx_valid && rx_addr_flag && rx_data == node_addr))
        |=> !rx_enable);

    a_r10_no_spurious_push: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !fifo_push);

endmodule

// File: tb/test_rs485_addr_gate.sv
module test_rs485_addr_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_addr_flag = 1'b0;
    logic       auto_mode = 1'b0;
    logic [7:0] node_addr = 8'h00;
    logic       sw_clear = 1'b0;
    logic       fifo_push;
    logic [7:0] fifo_data;
    logic       rx_enable;

    int n_cmp = 0;
    int n_bad = 0;

    int    m_flag = 0;
    int    m_push = 0;
    int    m_data = 0;
    string m_tag = "R1";
    string cur_tag = "R1";
    int    exp_q[$];
    int    got_q[$];

    always #5 clk = ~clk;

    rs485_addr_gate i_rs485_addr_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_addr_flag (rx_addr_flag),
        .auto_mode    (auto_mode),
        .node_addr    (node_addr),
        .sw_clear     (sw_clear),
        .fifo_push    (fifo_push),
        .fifo_data    (fifo_data),
        .rx_enable    (rx_enable)
    );

    // Behavioural reference model, updated on each rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = 0;
            m_push = 0;
            m_tag  = "R1";
        end else begin
            int old_flag;
            old_flag = m_flag;
            m_push = 0;
            m_tag  = cur_tag;
            if (sw_clear) m_flag = 0;
            if (rx_valid) begin
                if (!auto_mode) begin
                    m_push = 1;
                end else if (rx_addr_flag) begin
                    if (int'(rx_data) == int'(node_addr)) begin
                        m_push = 1;
                        m_flag = 1;
                    end else begin
                        m_flag = 0;
                    end
                end else begin
                    m_push = old_flag;
                end
            end
            if (m_push != 0) begin
                m_data = int'(rx_data);
                exp_q.push_back(m_data);
            end
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if (int'(fifo_push) != m_push || int'(rx_enable) != m_flag ||
            (m_push != 0 && int'(fifo_data) != m_data)) begin
            n_bad++;
            $display("FAIL %s: push=%0d data=%02h en=%0d expected push=%0d data=%02h en=%0d",
                     m_tag, fifo_push, fifo_data, rx_enable, m_push, m_data[7:0], m_flag);
        end
        if (fifo_push) got_q.push_back(int'(fifo_data));
    end

    task automatic send(input logic [7:0] b, input logic addr, input logic clr, input string tag);
        @(negedge clk);
        cur_tag      = tag;
        rx_valid     = 1'b1;
        rx_data      = b;
        rx_addr_flag = addr;
        sw_clear     = clr;
        @(negedge clk);
        rx_valid     = 1'b0;
        rx_addr_flag = 1'b0;
        sw_clear     = 1'b0;
        cur_tag      = "R10";
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        n_cmp++;
        if (rx_enable !== 1'b0 || fifo_push !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: en=%0b push=%0b expected 0 0", rx_enable, fifo_push);
        end
        rst_n = 1'b1;
        auto_mode = 1'b1;
        node_addr = 8'h5A;
        idle(2);
        send(8'h11, 1'b0, 1'b0, "R6");
        send(8'h5A, 1'b0, 1'b0, "R2");   // data equal to address: no open
        send(8'h5B, 1'b0, 1'b0, "R6");
        send(8'h5A, 1'b1, 1'b0, "R3");
        send(8'h01, 1'b0, 1'b0, "R5");
        send(8'hFF, 1'b0, 1'b0, "R5");
        send(8'h00, 1'b0, 1'b0, "R5");
        send(8'h5B, 1'b1, 1'b0, "R4");
        send(8'h22, 1'b0, 1'b0, "R6");
        send(8'h5A, 1'b1, 1'b0, "R3");
        send(8'h33, 1'b0, 1'b0, "R5");
        @(negedge clk); cur_tag = "R7"; sw_clear = 1'b1;
        @(negedge clk); sw_clear = 1'b0; cur_tag = "R10";
        send(8'h44, 1'b0, 1'b0, "R6");
        send(8'h5A, 1'b1, 1'b1, "R8");
        send(8'h55, 1'b0, 1'b1, "R7");
        send(8'h66, 1'b0, 1'b0, "R6");
        node_addr = 8'h00;
        send(8'h00, 1'b1, 1'b0, "R3");
        send(8'h01, 1'b1, 1'b0, "R4");
        node_addr = 8'hFF;
        send(8'hFF, 1'b1, 1'b0, "R3");
        send(8'h7E, 1'b0, 1'b0, "R5");
        auto_mode = 1'b0;
        send(8'h12, 1'b1, 1'b0, "R9");
        send(8'h34, 1'b0, 1'b0, "R9");
        @(negedge clk); cur_tag = "R9"; sw_clear = 1'b1;
        @(negedge clk); sw_clear = 1'b0; cur_tag = "R10";
        send(8'hFF, 1'b1, 1'b0, "R9");
        send(8'h56, 1'b0, 1'b0, "R9");
        auto_mode = 1'b1;
        send(8'hFF, 1'b1, 1'b0, "R3");
        send(8'h2A, 1'b1, 1'b0, "R4");
        idle(4);
        // R5: complete pushed sequence against the expected queue
        n_cmp++;
        if (got_q != exp_q) begin
            n_bad++;
            $display("FAIL R5: pushed %0d bytes, expected %0d bytes", got_q.size(), exp_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule